// File: doc/BRIEF.md
# Mode-Switched Output Port

This block is an 8-bit output-only port whose pins serve one of two purposes, chosen by the chip operating mode. In the two modes without an external bus (single-chip and bootstrap), the pins present the contents of a software-written data latch. In the two modes with an external bus (expanded and test), the same pins carry the low byte of the internal address, so that external memory can decode it.

Software reaches the port through a simple register bus made of a write strobe, write data and read data. A write always updates the latch, whatever the mode, so a value written while the bus owns the pins appears as soon as the chip returns to a latch-driven mode. The read data always reports the value sitting on the pin drivers, which is the latch in latch-driven modes and the address byte otherwise.

The pin drivers are registered. A write, a mode change or an address change reaches the pins at the next rising clock edge, and no combinational path runs from any input to a pin.

Top module: `mode_output_port`

## Requirements
- R1: While reset is asserted and just after it is released, the latch is zero and `pin_o` and `rd_data_o` read 8'h00.
- R2: When `mode_i` is 2'b00 (single-chip) or 2'b10 (bootstrap) at a rising edge, `pin_o` after that edge equals the latch contents after that edge. This includes data written at that same edge.
- R3: When `mode_i` is 2'b01 (expanded) or 2'b11 (test) at a rising edge, `pin_o` after that edge equals `addr_lo_i` as sampled at that edge.
- R4: A write (`wr_en_i` high at a rising edge) stores `wr_data_i` in the latch in every mode. A write made while `mode_i` is 2'b01 or 2'b11 does not change `pin_o`.
- R5: When `mode_i` changes from 2'b01 or 2'b11 to 2'b00 or 2'b10, the next edge drives `pin_o` with the latch value last written, with no new write needed.
- R6: `rd_data_o` always equals the value on `pin_o`, which is the level at the pin driver inputs.
- R7: Without a write, the latch holds its value, so `pin_o` stays constant in modes 2'b00 and 2'b10.
- R8: In modes 2'b00 and 2'b10, changes on `addr_lo_i` have no effect on `pin_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data (pin driver level) |
| mode_i | input | 2 | Operating mode: 00 single-chip, 01 expanded, 10 bootstrap, 11 test |
| addr_lo_i | input | 8 | Internal low address byte |
| pin_o | output | 8 | Port pin outputs |

## Verification
The bench compares the pins and the read data with a behavioural model on every clock. It concentrates on mode boundaries. A design that buffers only the registered latch would show a write one cycle late. A design that gates writes by mode would lose data written during expanded mode, and after a return to single-chip it would drive a stale value. Test mode is exercised separately because a decoder that checks only for 2'b01 would leave the latch on the pins there. Address churn in latch modes catches a select that is inverted or reads the wrong mode bit.

// File: rtl/outport_pkg.sv
package outport_pkg;

  localparam int unsigned PORT_W = 8;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    OPM_SINGLE = 2'b00,
    OPM_EXPAND = 2'b01,
    OPM_BOOT   = 2'b10,
    OPM_TEST   = 2'b11
  } opm_e;

  // Pins follow the latch only in the two modes without an external bus
  function automatic logic opm_uses_latch(input logic [MODE_W-1:0] mode);
    logic sel;
    case (opm_e'(mode))
      OPM_SINGLE: sel = 1'b1;
      OPM_BOOT:   sel = 1'b1;
      OPM_EXPAND: sel = 1'b0;
      OPM_TEST:   sel = 1'b0;
      default:    sel = 1'b0;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/outport_latch.sv
module outport_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] latch_q_o,
  output logic [W-1:0] latch_nxt_o
);

  logic [W-1:0] latch_q;
  logic [W-1:0] latch_nxt;

  // next-state: value the latch holds after the coming edge
  always_comb begin
    latch_nxt = latch_q;
    if (wr_en_i) begin
      latch_nxt = wr_data_i;
    end
  end

  // register with explicit clock enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
    end else if (wr_en_i) begin
      latch_q <= latch_nxt;
    end
  end

  assign latch_q_o   = latch_q;
  assign latch_nxt_o = latch_nxt;

  // R4: every write lands in the latch, independent of mode
  a_r4_write_stores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (latch_q == $past(wr_data_i)));

  // R7: no write, no change
  a_r7_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(latch_q));

endmodule

// File: rtl/outport_src_sel.sv
module outport_src_sel
  import outport_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [W-1:0]      latch_nxt_i,
  input  logic [W-1:0]      addr_i,
  output logic              sel_latch_o,
  output logic [W-1:0]      drv_nxt_o
);

  logic sel_latch;

  always_comb begin
    sel_latch = opm_uses_latch(mode_i);
  end

  // per-bit source select, replicated across the port width
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      if (sel_latch) begin
        drv_nxt_o[b] = latch_nxt_i[b];
      end else begin
        drv_nxt_o[b] = addr_i[b];
      end
    end
  end

  assign sel_latch_o = sel_latch;

endmodule

// File: rtl/outport_drive.sv
module outport_drive #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] drv_nxt_i,
  output logic [W-1:0] drv_q_o
);

  logic [W-1:0] drv_q;
  logic [W-1:0] drv_d;
  logic         drv_en;

  always_comb begin
    drv_en = 1'b1;
    drv_d  = drv_nxt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q <= '0;
    end else if (drv_en) begin
      drv_q <= drv_d;
    end
  end

  assign drv_q_o = drv_q;

endmodule

// File: rtl/mode_output_port.sv
module mode_output_port
  import outport_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wr_data_i,
  output logic [W-1:0]      rd_data_o,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [W-1:0]      addr_lo_i,
  output logic [W-1:0]      pin_o
);

  logic [W-1:0] latch_q;
  logic [W-1:0] latch_nxt;
  logic [W-1:0] drv_nxt;
  logic [W-1:0] drv_q;
  logic         sel_latch;

  outport_latch #(.W(W)) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .latch_q_o   (latch_q),
    .latch_nxt_o (latch_nxt)
  );

  outport_src_sel #(.W(W)) u_sel (
    .mode_i      (mode_i),
    .latch_nxt_i (latch_nxt),
    .addr_i      (addr_lo_i),
    .sel_latch_o (sel_latch),
    .drv_nxt_o   (drv_nxt)
  );

  outport_drive #(.W(W)) u_drive (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .drv_nxt_i (drv_nxt),
    .drv_q_o   (drv_q)
  );

  assign pin_o     = drv_q;
  assign rd_data_o = drv_q;

  // marks that one edge out of reset has passed, so $past is meaningful
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
    end
  end

  // R2: latch-driven modes put the latch on the pins at the same edge
  a_r2_pins_track_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && opm_uses_latch($past(mode_i))) |-> (pin_o == latch_q));

  // R3: bus modes put the sampled address byte on the pins
  a_r3_pins_track_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !opm_uses_latch($past(mode_i))) |-> (pin_o == $past(addr_lo_i)));

  // R5: leaving a bus mode restores the stored latch value
  a_r5_restore_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !opm_uses_latch($past(mode_i)) && opm_uses_latch(mode_i) && !wr_en_i)
      |=> (pin_o == $past(latch_q)));

  // R8: address churn is invisible while the latch owns the pins
  a_r8_addr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && opm_uses_latch(mode_i) && opm_uses_latch($past(mode_i)) && !wr_en_i)
      |=> $stable(pin_o));

endmodule

// File: tb/mode_output_port_bench.sv
`timescale 1ns/1ps
module mode_output_port_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       wr_en_i;
  logic [7:0] wr_data_i;
  logic [7:0] rd_data_o;
  logic [1:0] mode_i;
  logic [7:0] addr_lo_i;
  logic [7:0] pin_o;

  int n_cmp = 0;
  int n_bad = 0;
  int ref_latch = 0;
  int ref_pin = 0;

  always #2.5 clk_i = ~clk_i;

  mode_output_port u_mode_output_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .mode_i    (mode_i),
    .addr_lo_i (addr_lo_i),
    .pin_o     (pin_o)
  );

  function automatic bit latch_mode(input logic [1:0] m);
    return (m == 2'b00) || (m == 2'b10);
  endfunction

  task automatic check(input string tag);
    n_cmp++;
    if (pin_o !== ref_pin[7:0]) begin
      n_bad++;
      $display("FAIL %s pin_o actual=%h expected=%h", tag, pin_o, ref_pin[7:0]);
    end
    n_cmp++;
    if (rd_data_o !== ref_pin[7:0]) begin
      n_bad++;
      $display("FAIL R6 (%s) rd_data_o actual=%h expected=%h", tag, rd_data_o, ref_pin[7:0]);
    end
  endtask

  // drive at negedge, step the model, compare just after the rising edge
  task automatic step(input bit wr, input logic [7:0] d, input logic [1:0] m,
                      input logic [7:0] a, input string tag);
    @(negedge clk_i);
    wr_en_i   = wr;
    wr_data_i = d;
    mode_i    = m;
    addr_lo_i = a;
    if (wr) ref_latch = d;
    if (latch_mode(m)) ref_pin = ref_latch;
    else               ref_pin = a;
    @(posedge clk_i);
    #1;
    check(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_ni    = 1'b0;
    wr_en_i   = 1'b1;
    wr_data_i = 8'hA5;
    mode_i    = 2'b00;
    addr_lo_i = 8'h3C;
    repeat (3) @(posedge clk_i);
    #1;
    check("R1");
    @(negedge clk_i);
    rst_ni  = 1'b1;
    wr_en_i = 1'b0;
    #1;
    check("R1");

    // R2 single-chip and bootstrap writes, same-edge visibility
    step(1, 8'h5A, 2'b00, 8'h11, "R2");
    step(1, 8'hFF, 2'b00, 8'h22, "R2");
    step(1, 8'h81, 2'b10, 8'h33, "R2");
    // R7 hold, R8 address ignored in latch modes
    for (int i = 0; i < 6; i++) step(0, 8'h00, 2'b10, 8'(i * 37), "R8");
    for (int i = 0; i < 4; i++) step(0, 8'hEE, 2'b00, 8'(i + 200), "R7");
    // R3 expanded follows address
    for (int i = 0; i < 8; i++) step(0, 8'h00, 2'b01, 8'(1 << i), "R3");
    // R4 writes in expanded mode stored but not shown
    step(1, 8'hC3, 2'b01, 8'h40, "R4");
    step(0, 8'h00, 2'b01, 8'h41, "R4");
    // R5 back to single-chip without a write
    step(0, 8'h00, 2'b00, 8'h42, "R5");
    // R3 test mode behaves as expanded, R4 write in test mode
    step(0, 8'h00, 2'b11, 8'h99, "R3");
    step(1, 8'h3E, 2'b11, 8'h98, "R4");
    step(0, 8'h00, 2'b11, 8'h00, "R3");
    // R5 test to bootstrap
    step(0, 8'h00, 2'b10, 8'h77, "R5");
    // R2 write in the same cycle as a switch into a latch mode
    step(0, 8'h00, 2'b01, 8'h10, "R3");
    step(1, 8'h6B, 2'b00, 8'h10, "R2");
    // mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [1:0] m;
      m = 2'($urandom);
      step(1'($urandom), 8'($urandom), m, 8'($urandom), latch_mode(m) ? "R2" : "R3");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule